// File: doc/BRIEF.md
# Gated Input Pulse Truncator

This block limits how long each high pulse of a single-bit input can last. It passes the input through an internal gate. The gate is open whenever the block is idle. A rising edge on the input therefore appears at the output at once, apart from a fixed synchronizer delay. From that edge the block counts clock cycles. When the count reaches the programmed limit, the gate closes and the output drops, even though the input is still high. The gate opens again as soon as the input returns low, ready for the next pulse.

The limit is a plain input bus, `max_width`, expressed in clock cycles. The block reads it only on the cycle of a detected rising edge. Software or neighbouring logic can change it at any time without disturbing a pulse that is already under way. The input is asynchronous to `clk` and goes through a synchronizer chain `SYNC_STAGES` flops deep. All timing below is measured on the synchronized signal: the output follows `sig_in` with a latency of `SYNC_STAGES` clock cycles.

Top module: `pulse_truncator`

## Requirements
- R1: While `rst_n` is low, `sig_out` is low, whatever the level of `sig_in`. This includes an asynchronous reset asserted in the middle of a pulse.
- R2: When the limit is nonzero, `sig_out` rises exactly `SYNC_STAGES` clock cycles after `sig_in` rises. The leading edge is not delayed further.
- R3: When the input stays high for longer than the limit N (N ≥ 1), `sig_out` stays high for exactly N cycles and then stays low until the input falls.
- R4: When the input falls before N cycles have passed, the pulse is not cut: `sig_out` is high for exactly as many cycles as the synchronized input.
- R5: A limit of zero keeps `sig_out` low for the whole high interval of the input.
- R6: The limit is sampled on the cycle in which a rising edge is detected. A new value applied while a pulse is high changes only the pulses that start later.
- R7: Once the input has been low for a single synchronized cycle, the gate is open again. The next pulse is truncated independently of the previous one.
- R8: `sig_out` is never high while the synchronized input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Asynchronous pulse input to be shortened |
| max_width | input | WIDTH_W | Maximum output high time in clock cycles; 0 blocks the pulse |
| sig_out | output | 1 | Input pulse masked by the internal gate |

## Verification
Two cases are hard to reach from the ports. The first is a pulse that is cut short and whose input then drops for only one synchronized cycle before rising again. This exercises the return from the closed state straight into a fresh rising-edge detection, so the bench drives exact bit patterns cycle by cycle rather than free-running pulses. The second is a change to `max_width` in the middle of a pulse. The bench applies it a few cycles after the leading edge and then runs a second pulse without rewriting the value, showing that the new value governs only that later pulse.

// File: rtl/pulse_truncator.sv
module pulse_truncator #(
  parameter int WIDTH_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sig_in,
  input  logic [WIDTH_W-1:0] max_width,
  output logic               sig_out
);

  typedef enum logic [1:0] {G_OPEN, G_TIMING, G_SHUT} gate_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl, lvl_q, rise, zero_w, short_w, gate;
  gate_t                  st;
  logic [WIDTH_W-1:0]     left;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= sig_in;

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sync_q[i] <= 1'b0;
      else        sync_q[i] <= sync_q[i-1];
  end

  assign lvl     = sync_q[SYNC_STAGES-1];
  assign rise    = lvl & ~lvl_q;
  assign zero_w  = (max_width == '0);
  assign short_w = zero_w | (max_width == WIDTH_W'(1));
  assign gate    = (st == G_TIMING) | ((st == G_OPEN) & ~(rise & zero_w));
  assign sig_out = lvl & gate;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= G_OPEN;
      left <= '0;
    end else begin
      case (st)
        G_OPEN:
          if (rise) begin
            left <= max_width - WIDTH_W'(1);
            st   <= short_w ? G_SHUT : G_TIMING;
          end
        G_TIMING:
          if (!lvl)                        st   <= G_OPEN;
          else if (left == WIDTH_W'(1))    st   <= G_SHUT;
          else                             left <= left - WIDTH_W'(1);
        G_SHUT:
          if (!lvl) st <= G_OPEN;
        default: st <= G_OPEN;
      endcase
    end
  end

endmodule

// File: rtl/pulse_truncator_chk.sv
module pulse_truncator_chk #(
  parameter int WIDTH_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sig_in,
  input logic [WIDTH_W-1:0] max_width,
  input logic               sig_out
);

  logic [SYNC_STAGES-1:0] dly;
  logic                   d_lvl, d_lvl_q, d_rise;
  logic [WIDTH_W-1:0]     wl, wl_eff;
  logic [WIDTH_W:0]       run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dly[0] <= 1'b0;
    else        dly[0] <= sig_in;

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) dly[i] <= 1'b0;
      else        dly[i] <= dly[i-1];
  end

  assign d_lvl  = dly[SYNC_STAGES-1];
  assign d_rise = d_lvl & ~d_lvl_q;
  assign wl_eff = d_rise ? max_width : wl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      d_lvl_q <= 1'b0;
      wl      <= '0;
      run     <= '0;
    end else begin
      d_lvl_q <= d_lvl;
      wl      <= wl_eff;
      run     <= sig_out ? run + 1'b1 : '0;
    end

  // R8
  out_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_out |-> d_lvl);

  // R2
  lead_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rise && max_width != '0) |-> sig_out);

  // R5
  zero_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rise && max_width == '0) |-> !sig_out);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_out |-> (run < {1'b0, wl_eff}));

  // R4
  hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_lvl && !d_rise && run != '0 && run < {1'b0, wl}) |-> sig_out);

endmodule

bind pulse_truncator pulse_truncator_chk #(
  .WIDTH_W(WIDTH_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
  .max_width(max_width), .sig_out(sig_out)
);

// File: tb/test_pulse_truncator.sv
`timescale 1ns/100ps
module test_pulse_truncator;
  localparam int W    = 8;
  localparam int SYNC = 2;
  localparam int NVEC = 8;
  // {input high cycles, limit}
  localparam int VEC [NVEC][2] = '{
    '{6, 3}, '{2, 5}, '{5, 5}, '{5, 1},
    '{7, 0}, '{1, 1}, '{12, 9}, '{50, 200}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sig_in = 1'b0;
  logic [W-1:0] max_width = '0;
  logic         sig_out;
  int           total = 0;
  int           bad = 0;
  int           cyc = 0;
  bit           done = 1'b0;

  pulse_truncator #(.WIDTH_W(W), .SYNC_STAGES(SYNC)) i_pulse_truncator (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
    .max_width(max_width), .sig_out(sig_out)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic play(input logic [63:0] pat, input int n,
                      input int chg_at, input int chg_val,
                      output int hi, output int first, output int edges);
    logic prev;
    hi = 0; first = -1; edges = 0; prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sig_out) begin
        hi++;
        if (first < 0) first = i;
        if (!prev) edges++;
      end
      prev = sig_out;
      sig_in = pat[i];
      if (i == chg_at) max_width = W'(chg_val);
    end
  endtask

  initial begin
    int hi, first, edges, len, w, exp;
    sig_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 out low in reset, input high", int'(sig_out), 0);
    sig_in = 1'b0;
    repeat (SYNC + 1) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out low after release", int'(sig_out), 0);

    for (int v = 0; v < NVEC; v++) begin
      len = VEC[v][0];
      w   = VEC[v][1];
      exp = (len < w) ? len : w;
      max_width = W'(w);
      play((64'(1) << len) - 64'(1), len + SYNC + 3, -1, 0, hi, first, edges);
      chk($sformatf("R3/R4/R5 high time len=%0d w=%0d", len, w), hi, exp);
      chk($sformatf("R2 leading edge delay len=%0d w=%0d", len, w), first, (exp > 0) ? SYNC : -1);
      chk($sformatf("R8 single output pulse len=%0d w=%0d", len, w), edges, (exp > 0) ? 1 : 0);
    end

    // R6: width change mid-pulse applies only to the next pulse
    max_width = W'(3);
    play(64'h3FF, 15, 3, 8, hi, first, edges);
    chk("R6 mid-pulse change ignored", hi, 3);
    play(64'h3FF, 15, -1, 0, hi, first, edges);
    chk("R6 new width on next edge", hi, 8);

    // R7: one low cycle between a truncated pulse and the next
    max_width = W'(2);
    play(64'h1EF, 14, -1, 0, hi, first, edges);
    chk("R7 rearm after one low cycle, high", hi, 4);
    chk("R7 rearm after one low cycle, pulses", edges, 2);
    max_width = W'(10);
    play(64'h1EF, 14, -1, 0, hi, first, edges);
    chk("R4 untruncated back-to-back, high", hi, 8);
    chk("R4 untruncated back-to-back, pulses", edges, 2);

    // R5: zero limit on a long pulse
    max_width = '0;
    play(64'hFFFFF, 25, -1, 0, hi, first, edges);
    chk("R5 zero limit long pulse", hi, 0);

    // R1: asynchronous reset in the middle of a pulse
    max_width = W'(20);
    sig_in = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
    chk("R1 pulse active before reset", int'(sig_out), 1);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async reset mid-pulse", int'(sig_out), 0);
    @(negedge clk);
    sig_in = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", int'(sig_out), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule